// File: doc/BRIEF.md
# Stack-Addressed Floating-Point Register File

This block holds eight floating-point operands that are addressed as a stack. A 3-bit top pointer rotates around the eight physical slots. Each slot has a tag that marks it as valid or empty. Stack-relative position i refers to physical slot (top + i) mod 8. The surrounding datapath issues one operation per clock: it can push a value, read the top, read the top and pop it, copy the top into a deeper position and pop, swap the top with a deeper position, or move a deeper position onto the top when a flag condition holds.

Operations arrive as a valid/ready stream. `op_ready` is always high, so the block never applies back-pressure. An operation is accepted on every rising edge where `op_valid` is high, and ops may be issued back to back. Read results leave on a one-cycle `out_valid` pulse with no ready signal, so the consumer must take them on that cycle.

Any operation that would overwrite a valid slot, or read an empty one, is refused. The refusal is reported on a fault pulse, and no stored state changes. The pointer and the tag vector are visible at all times as plain status outputs.

Top module: `fpstk_regfile`

## Requirements
- R1: After reset, `top_ptr` is 0, all bits of `tags` are 0 (empty), and `done`, `fault_ovf`, `fault_unf` and `out_valid` are low.
- R2: Position i (`op_idx`) addresses physical slot (`top_ptr` + i) mod 8. Bit k of `tags` is 1 when physical slot k holds a valid value.
- R3: Push (`op_code` 0) on a slot (`top_ptr`-1) mod 8 that is empty does three things: it sets `top_ptr` to that slot, stores `push_data` there, and tags the slot valid. If that slot is already valid, the push raises `fault_ovf` and changes nothing.
- R4: Store (`op_code` 1) pulses `out_valid` and presents the value at position 0 on `out_data`. `top_ptr` and `tags` stay unchanged.
- R5: Store-and-pop (`op_code` 2) outputs position 0 as in R4, then clears the tag of that slot and increments `top_ptr` modulo 8.
- R6: Copy-and-pop (`op_code` 3) writes position 0 into position `op_idx`, using the pointer from before the pop, and tags that slot valid. It then pops as in R5. With `op_idx` 0, the slot ends up empty.
- R7: Exchange (`op_code` 4) swaps the values at position 0 and position `op_idx`. `top_ptr` and `tags` do not change.
- R8: Conditional move (`op_code` 5) copies position `op_idx` into position 0 when the condition selected by `op_cond` holds. The encodings are: 0 when cf=1; 1 when cf=0; 2 when zf=1; 3 when zf=0; 4 when cf=1 or zf=1; 5 when cf=0 and zf=0; 6 when pf=1; 7 when pf=0.
- R9: A conditional move whose condition is false changes no stored value, `top_ptr` or `tags`.
- R10: The following raise `fault_unf` and change nothing: store, store-and-pop or copy-and-pop with position 0 empty; and exchange or conditional move with either position 0 or position `op_idx` empty. The underflow check is made before the condition is evaluated.
- R11: Every accepted operation gives exactly one `done` pulse on the following cycle, including faulted ones and ones with a false condition. Reserved codes 6 and 7 complete with `done` and change nothing.
- R12: `op_ready` is always high, and the operation's effects are visible on the cycle after it is accepted, including for back-to-back operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation valid |
| op_ready | output | 1 | Operation accepted (always high) |
| op_code | input | 3 | Operation select |
| op_idx | input | 3 | Stack position i |
| op_cond | input | 3 | Condition select for conditional move |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_pf | input | 1 | Parity/unordered flag |
| push_data | input | DW | Value to push |
| out_valid | output | 1 | Read result pulse |
| out_data | output | DW | Value of position 0 at the read |
| top_ptr | output | 3 | Current top pointer |
| tags | output | 8 | Per-slot valid tags |
| done | output | 1 | Operation completed pulse |
| fault_ovf | output | 1 | Push onto a valid slot refused |
| fault_unf | output | 1 | Access to an empty slot refused |

## Verification
A wrong pointer or tag update shows up on `top_ptr` and `tags` on the cycle right after the operation. A wrong value written into a slot stays hidden until a later store reaches that slot, which may be many operations later. For that reason the bench issues stores often, and after each exchange, move and copy it reads the affected positions back. A faulty fault decision appears one cycle after the operation, both as a wrong fault pulse and as a pointer or tag change that should not have happened.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  localparam int unsigned PTR_W = 3;
  localparam int unsigned NENT  = 1 << PTR_W;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_STORE = 3'd1,
    OP_STPOP = 3'd2,
    OP_CPPOP = 3'd3,
    OP_XCHG  = 3'd4,
    OP_CMOV  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    CC_B   = 3'd0,
    CC_NB  = 3'd1,
    CC_E   = 3'd2,
    CC_NE  = 3'd3,
    CC_BE  = 3'd4,
    CC_NBE = 3'd5,
    CC_U   = 3'd6,
    CC_NU  = 3'd7
  } cond_e;
endpackage

// File: rtl/fpstk_cond_eval.sv
module fpstk_cond_eval
  import fpstk_pkg::*;
(
  input  logic [2:0] sel,
  input  logic       cf,
  input  logic       zf,
  input  logic       pf,
  output logic       hit
);
  cond_e sel_e;
  assign sel_e = cond_e'(sel);

  always_comb begin
    unique case (sel_e)
      CC_B:    hit = cf;
      CC_NB:   hit = !cf;
      CC_E:    hit = zf;
      CC_NE:   hit = !zf;
      CC_BE:   hit = cf || zf;
      CC_NBE:  hit = !cf && !zf;
      CC_U:    hit = pf;
      default: hit = !pf;
    endcase
  end
endmodule

// File: rtl/fpstk_decode.sv
module fpstk_decode
  import fpstk_pkg::*;
#(
  parameter int unsigned PW = PTR_W,
  localparam int unsigned NE = 1 << PW
) (
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [PW-1:0] op_idx,
  input  logic [PW-1:0] top,
  input  logic [NE-1:0] tag_vec,
  input  logic          cond_hit,
  output logic [PW-1:0] p0,
  output logic [PW-1:0] pi,
  output logic [PW-1:0] pm,
  output logic          ovf,
  output logic          unf,
  output logic          push_en,
  output logic          pop_en,
  output logic          wr0_en,
  output logic          wri_en,
  output logic          rd_en
);
  op_e code_e;
  logic v0, vi;

  assign code_e = op_e'(op_code);
  assign p0 = top;
  assign pi = top + op_idx;
  assign pm = top - 1'b1;
  assign v0 = tag_vec[p0];
  assign vi = tag_vec[pi];

  always_comb begin
    ovf = 1'b0; unf = 1'b0;
    push_en = 1'b0; pop_en = 1'b0;
    wr0_en = 1'b0; wri_en = 1'b0; rd_en = 1'b0;
    if (op_valid) begin
      unique case (code_e)
        OP_PUSH:  if (tag_vec[pm]) ovf = 1'b1; else push_en = 1'b1;
        OP_STORE: if (!v0) unf = 1'b1; else rd_en = 1'b1;
        OP_STPOP: if (!v0) unf = 1'b1;
                  else begin rd_en = 1'b1; pop_en = 1'b1; end
        OP_CPPOP: if (!v0) unf = 1'b1;
                  else begin wri_en = 1'b1; pop_en = 1'b1; end
        OP_XCHG:  if (!v0 || !vi) unf = 1'b1;
                  else begin wr0_en = 1'b1; wri_en = 1'b1; end
        OP_CMOV:  if (!v0 || !vi) unf = 1'b1;
                  else wr0_en = cond_hit;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/fpstk_slot.sv
module fpstk_slot #(
  parameter int unsigned DW = 80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_push,
  input  logic          sel_wr0,
  input  logic          sel_wri,
  input  logic          sel_pop,
  input  logic [DW-1:0] push_data,
  input  logic [DW-1:0] src_sti,
  input  logic [DW-1:0] src_st0,
  output logic [DW-1:0] q,
  output logic          valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q     <= '0;
      valid <= 1'b0;
    end else begin
      if (sel_push)     q <= push_data;
      else if (sel_wri) q <= src_st0;
      else if (sel_wr0) q <= src_sti;
      if (sel_pop)                    valid <= 1'b0;
      else if (sel_push || sel_wri)   valid <= 1'b1;
    end
  end
endmodule

// File: rtl/fpstk_regfile.sv
module fpstk_regfile
  import fpstk_pkg::*;
#(
  parameter int unsigned DW = 80,
  localparam int unsigned PW = PTR_W,
  localparam int unsigned NE = 1 << PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [2:0]    op_code,
  input  logic [PW-1:0] op_idx,
  input  logic [2:0]    op_cond,
  input  logic          flag_cf,
  input  logic          flag_zf,
  input  logic          flag_pf,
  input  logic [DW-1:0] push_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [PW-1:0] top_ptr,
  output logic [NE-1:0] tags,
  output logic          done,
  output logic          fault_ovf,
  output logic          fault_unf
);
  logic [DW-1:0] slot_q [NE];
  logic [PW-1:0] p0, pi, pm;
  logic cond_hit, ovf, unf, push_en, pop_en, wr0_en, wri_en, rd_en;
  logic [DW-1:0] st0_val, sti_val;

  assign op_ready = 1'b1;

  fpstk_cond_eval u_cond (
    .sel(op_cond), .cf(flag_cf), .zf(flag_zf), .pf(flag_pf), .hit(cond_hit)
  );

  fpstk_decode #(.PW(PW)) u_dec (
    .op_valid(op_valid), .op_code(op_code), .op_idx(op_idx), .top(top_ptr),
    .tag_vec(tags), .cond_hit(cond_hit), .p0(p0), .pi(pi), .pm(pm),
    .ovf(ovf), .unf(unf), .push_en(push_en), .pop_en(pop_en),
    .wr0_en(wr0_en), .wri_en(wri_en), .rd_en(rd_en)
  );

  assign st0_val = slot_q[p0];
  assign sti_val = slot_q[pi];

  for (genvar k = 0; k < NE; k++) begin : g_slot
    fpstk_slot #(.DW(DW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .sel_push(push_en && (pm == PW'(k))),
      .sel_wr0(wr0_en && (p0 == PW'(k))),
      .sel_wri(wri_en && (pi == PW'(k))),
      .sel_pop(pop_en && (p0 == PW'(k))),
      .push_data(push_data), .src_sti(sti_val), .src_st0(st0_val),
      .q(slot_q[k]), .valid(tags[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_ptr   <= '0;
      done      <= 1'b0;
      fault_ovf <= 1'b0;
      fault_unf <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (push_en)     top_ptr <= pm;
      else if (pop_en) top_ptr <= top_ptr + 1'b1;
      done      <= op_valid;
      fault_ovf <= ovf;
      fault_unf <= unf;
      out_valid <= rd_en;
      if (rd_en) out_data <= st0_val;
    end
  end
endmodule

// File: rtl/fpstk_regfile_chk.sv
module fpstk_regfile_chk #(
  parameter int unsigned PW = 3,
  localparam int unsigned NE = 1 << PW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [2:0]    op_code,
  input logic [PW-1:0] top_ptr,
  input logic [NE-1:0] tags,
  input logic          done,
  input logic          fault_ovf,
  input logic          fault_unf,
  input logic          out_valid
);
  logic [PW-1:0] top_dn, top_up;
  assign top_dn = top_ptr - 1'b1;
  assign top_up = top_ptr + 1'b1;

  AST_PUSH_MOVES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd0 && !tags[top_dn]) |=> (top_ptr == $past(top_dn))); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd0 && tags[top_dn]) |=> (fault_ovf && $stable(top_ptr) && $stable(tags))); // R3
  AST_STORE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd1) |=> ($stable(top_ptr) && $stable(tags))); // R4
  AST_POP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd2 && tags[top_ptr]) |=> (top_ptr == $past(top_up) && out_valid)); // R5
  AST_XCHG_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd4) |=> ($stable(top_ptr) && $stable(tags))); // R7
  AST_UNDERFLOW_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_unf |-> ($stable(top_ptr) && $stable(tags) && !out_valid)); // R10
  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_ovf && fault_unf)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> done); // R11
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid) |=> !done); // R11
endmodule

bind fpstk_regfile fpstk_regfile_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .top_ptr(top_ptr), .tags(tags), .done(done), .fault_ovf(fault_ovf),
  .fault_unf(fault_unf), .out_valid(out_valid)
);

// File: tb/fpstk_regfile_bench.sv
module fpstk_regfile_bench;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic op_valid, op_ready;
  logic [2:0] op_code, op_idx, op_cond;
  logic flag_cf, flag_zf, flag_pf;
  logic [DW-1:0] push_data, out_data;
  logic out_valid, done, fault_ovf, fault_unf;
  logic [2:0] top_ptr;
  logic [7:0] tags;

  int n_chk = 0;
  int n_fail = 0;

  logic [DW-1:0] m_data [8];
  logic [7:0] m_tag;
  logic [2:0] m_top;

  always #10 clk = ~clk;

  fpstk_regfile #(.DW(DW)) u_fpstk_regfile (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_idx(op_idx), .op_cond(op_cond),
    .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_pf(flag_pf),
    .push_data(push_data), .out_valid(out_valid), .out_data(out_data),
    .top_ptr(top_ptr), .tags(tags), .done(done),
    .fault_ovf(fault_ovf), .fault_unf(fault_unf)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit cond_true(logic [2:0] s, logic cf, logic zf, logic pf);
    case (s)
      3'd0: return cf;
      3'd1: return !cf;
      3'd2: return zf;
      3'd3: return !zf;
      3'd4: return cf || zf;
      3'd5: return !cf && !zf;
      3'd6: return pf;
      default: return !pf;
    endcase
  endfunction

  // Called at a falling edge: drives one op, updates the model, checks at the next falling edge.
  task automatic do_op(logic [2:0] code, logic [2:0] idx, logic [2:0] cs,
                       logic cf, logic zf, logic pf, logic [DW-1:0] d, string rq);
    logic [2:0] p0, pi, pm;
    bit e_ovf, e_unf, e_out;
    logic [DW-1:0] e_data, tmp;
    string req;
    req = rq;
    p0 = m_top; pi = m_top + idx; pm = m_top - 3'd1;
    e_ovf = 0; e_unf = 0; e_out = 0; e_data = '0;
    op_valid = 1'b1; op_code = code; op_idx = idx; op_cond = cs;
    flag_cf = cf; flag_zf = zf; flag_pf = pf; push_data = d;
    chk("R12", "op_ready", {31'd0, op_ready}, 32'd1);
    case (code)
      3'd0: if (m_tag[pm]) e_ovf = 1;
            else begin m_top = pm; m_data[pm] = d; m_tag[pm] = 1'b1; end
      3'd1: if (!m_tag[p0]) e_unf = 1; else begin e_out = 1; e_data = m_data[p0]; end
      3'd2: if (!m_tag[p0]) e_unf = 1;
            else begin e_out = 1; e_data = m_data[p0]; m_tag[p0] = 1'b0; m_top = p0 + 3'd1; end
      3'd3: if (!m_tag[p0]) e_unf = 1;
            else begin m_data[pi] = m_data[p0]; m_tag[pi] = 1'b1; m_tag[p0] = 1'b0; m_top = p0 + 3'd1; end
      3'd4: if (!m_tag[p0] || !m_tag[pi]) e_unf = 1;
            else begin tmp = m_data[p0]; m_data[p0] = m_data[pi]; m_data[pi] = tmp; end
      3'd5: if (!m_tag[p0] || !m_tag[pi]) e_unf = 1;
            else if (cond_true(cs, cf, zf, pf)) m_data[p0] = m_data[pi];
            else if (req == "R8") req = "R9";
      default: ;
    endcase
    @(negedge clk);
    op_valid = 1'b0;
    chk("R11", "done", {31'd0, done}, 32'd1);
    chk("R3", "fault_ovf", {31'd0, fault_ovf}, {31'd0, e_ovf});
    chk("R10", "fault_unf", {31'd0, fault_unf}, {31'd0, e_unf});
    chk(req, "out_valid", {31'd0, out_valid}, {31'd0, e_out});
    if (e_out) chk(req, "out_data", {16'd0, out_data}, {16'd0, e_data});
    chk(req, "top_ptr", {29'd0, top_ptr}, {29'd0, m_top});
    chk(req, "tags", {24'd0, tags}, {24'd0, m_tag});
  endtask

  function automatic string req_of(logic [2:0] c);
    case (c)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic show_pos(logic [2:0] i, string rq);
    do_op(3'd4, i, 3'd0, 0, 0, 0, '0, "R2");
    do_op(3'd1, 3'd0, 3'd0, 0, 0, 0, '0, rq);
    do_op(3'd4, i, 3'd0, 0, 0, 0, '0, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_idx = '0; op_cond = '0;
    flag_cf = 0; flag_zf = 0; flag_pf = 0; push_data = '0;
    m_top = '0; m_tag = '0;
    for (int k = 0; k < 8; k++) m_data[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "top_ptr", {29'd0, top_ptr}, 32'd0);
    chk("R1", "tags", {24'd0, tags}, 32'd0);
    chk("R1", "done", {31'd0, done}, 32'd0);
    chk("R1", "faults", {30'd0, fault_ovf, fault_unf}, 32'd0);
    chk("R1", "out_valid", {31'd0, out_valid}, 32'd0);

    // R10 underflow on empty stack
    do_op(3'd1, 3'd0, 3'd0, 0, 0, 0, '0, "R10");
    do_op(3'd3, 3'd2, 3'd0, 0, 0, 0, '0, "R10");
    // R3 wrap 0 -> 7 and fill, then overflow
    for (int k = 0; k < 8; k++) do_op(3'd0, 3'd0, 3'd0, 0, 0, 0, DW'(16'h1000 + k), "R3");
    do_op(3'd0, 3'd0, 3'd0, 0, 0, 0, 16'hdead, "R3");
    // R2 / R7 mapping through exchange
    for (int i = 1; i < 8; i++) show_pos(3'(i), "R2");
    // R8 / R9 each condition with several flag patterns
    for (int s = 0; s < 8; s++)
      for (int f = 0; f < 8; f += 3) begin
        do_op(3'd5, 3'(s + 1), 3'(s), f[0], f[1], f[2], '0, "R8");
        do_op(3'd1, 3'd0, 3'd0, 0, 0, 0, '0, "R8");
      end
    // R11 reserved codes and an idle cycle
    do_op(3'd6, 3'd1, 3'd0, 0, 0, 0, 16'h5555, "R11");
    do_op(3'd7, 3'd3, 3'd0, 0, 0, 0, 16'h5555, "R11");
    @(negedge clk);
    chk("R11", "done idle", {31'd0, done}, 32'd0);
    // R6 copy-and-pop with i=5 and i=0, R5 pops, R10 cmov touching empty
    do_op(3'd3, 3'd5, 3'd0, 0, 0, 0, '0, "R6");
    show_pos(3'd4, "R6");
    do_op(3'd3, 3'd0, 3'd0, 0, 0, 0, '0, "R6");
    do_op(3'd5, 3'd7, 3'd1, 0, 0, 0, '0, "R10");
    do_op(3'd4, 3'd7, 3'd0, 0, 0, 0, '0, "R10");
    do_op(3'd2, 3'd0, 3'd0, 0, 0, 0, '0, "R5");
    do_op(3'd2, 3'd0, 3'd0, 0, 0, 0, '0, "R5");

    // constrained random, back to back (R12)
    for (int n = 0; n < 1500; n++) begin
      logic [2:0] c;
      int r;
      r = $urandom_range(0, 99);
      if (r < 30) c = 3'd0;
      else if (r < 50) c = 3'd1;
      else if (r < 62) c = 3'd2;
      else if (r < 70) c = 3'd3;
      else if (r < 80) c = 3'd4;
      else if (r < 96) c = 3'd5;
      else c = 3'($urandom_range(6, 7));
      do_op(c, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            DW'($urandom), req_of(c));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule